// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block turns a single access request from a small 8-bit processor core into an external bus cycle on a time-shared address/data bus. The core supplies the direction (read or write), the space (memory or I/O), a 16-bit address and, for writes, one byte of write data. The controller places the upper address byte on dedicated output lines for the whole cycle. The lower address byte goes out on a shared bidirectional byte lane, and the same lane carries the data later in the cycle.

A basic cycle takes three T-states of one clock each. In the first state the controller puts the low address on the lane and raises the address strobe for that state only. In the second and third states it asserts the active-low read or write strobe. For a write it drives the data on the lane. For a read it releases the lane to the external device and samples the lane at the end of the third state.

The block also contains the external low-address holding register. This register captures the lane while the address strobe is high, so that the address stays valid after the lane has turned around for data. A one-cycle done pulse returns the result to the core. A space-select output and a two-bit status code identify the access in progress.

Top module: `mbus_cycle_ctrl`

## Requirements
- R1: After reset the controller is idle: `req_ready` is 1, `ale` is 0, `rd_n` and `wr_n` are 1, `stat` is 00 and `done` is 0.
- R2: A request presented while `req_ready` is 1 starts the first T-state on the next clock. In that state `ale` is 1 for exactly one clock, `ad` carries address bits 7..0 and both strobes are high.
- R3: `addr_hi` carries address bits 15..8 in all three T-states and does not change while a strobe is low.
- R4: In a read, `rd_n` is low in the second and third T-states only, and the controller does not drive `ad` in those states.
- R5: In a write, `wr_n` is low in the second and third T-states only, and `ad` carries the write data in both of them.
- R6: `io_m` is 0 for a memory access and 1 for an I/O access, throughout the three T-states.
- R7: `stat` is 10 during a read cycle, 01 during a write cycle and 00 when idle.
- R8: `lat_addr_lo` holds address bits 7..0 from the second T-state onward and keeps that value until the next address strobe.
- R9: In the clock after the third T-state, `done` is 1 for exactly one clock. For a read, `rdata` then holds the lane value sampled at the end of the third T-state.
- R10: `rd_n` and `wr_n` are never low together, and neither is low while `ale` is 1.
- R11: `req_valid` is ignored while a cycle is in progress: the running cycle's address is unchanged, and no new address strobe follows unless a request is presented while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one T-state per period |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Core requests a bus cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Controller idle and able to accept a request |
| done | output | 1 | One-clock pulse after the last T-state |
| rdata | output | 8 | Read data captured at the end of the third T-state |
| addr_hi | output | 8 | Upper address byte, dedicated lines |
| ad | inout | 8 | Shared low-address / data lane |
| ale | output | 1 | Address strobe, high in the first T-state |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | Space select: 0 memory, 1 I/O |
| stat | output | 2 | Operation code: 10 read, 01 write, 00 idle |
| lat_addr_lo | output | 8 | Recovered low address byte from the holding register |

## Verification
The assertions assume that the external device drives `ad` only while `rd_n` is low, so that the lane has a single driver at any time. They also assume that the core treats `req_ready` as the only acceptance signal. The bench models the device with a driver that is enabled only by `rd_n`. It raises `req_valid` in the middle of a running cycle to confirm that such a request is dropped. Random addresses, data, directions and spaces are mixed with directed cases at the address and data extremes.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  typedef enum logic [1:0] {
    TS_IDLE = 2'd0,
    TS_T1   = 2'd1,
    TS_T2   = 2'd2,
    TS_T3   = 2'd3
  } tstate_e;

  localparam logic [1:0] ST_NONE  = 2'b00;
  localparam logic [1:0] ST_WRITE = 2'b01;
  localparam logic [1:0] ST_READ  = 2'b10;
endpackage

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  output tstate_e state_q,
  output logic    accept,
  output logic    done_q
);
  tstate_e state_d;
  logic    done_d;

  always_comb begin
    accept  = (state_q == TS_IDLE) && req_valid;
    state_d = state_q;
    case (state_q)
      TS_IDLE: if (accept) state_d = TS_T1;
      TS_T1:   state_d = TS_T2;
      TS_T2:   state_d = TS_T3;
      default: state_d = TS_IDLE;
    endcase
    done_d = (state_q == TS_T3);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TS_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  // R2: an accepted request opens T1 on the next edge
  p_t1_follows_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (state_q == TS_T1));
  // R9: done is a single-cycle pulse
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/mbus_lane.sv
module mbus_lane
  import mbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tstate_e       state,
  input  logic          accept,
  input  logic          req_write,
  input  logic          req_io,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [AW-DW-1:0] addr_hi,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          io_m,
  output logic [1:0]    stat,
  output logic [DW-1:0] rdata
);
  localparam int HW = AW - DW;

  logic          cap_write_q, cap_io_q;
  logic [AW-1:0] cap_addr_q;
  logic [DW-1:0] cap_wdata_q;
  logic [DW-1:0] rdata_q;
  logic          busy, strobe_on, rd_sample;

  always_comb begin
    busy      = (state != TS_IDLE);
    strobe_on = (state == TS_T2) || (state == TS_T3);
    rd_sample = (state == TS_T3) && !cap_write_q;
    ale       = (state == TS_T1);
    rd_n      = !(strobe_on && !cap_write_q);
    wr_n      = !(strobe_on && cap_write_q);
    ad_oe     = ale || (strobe_on && cap_write_q);
    ad_out    = ale ? cap_addr_q[DW-1:0] : cap_wdata_q;
    addr_hi   = cap_addr_q[AW-1:DW];
    io_m      = busy && cap_io_q;
    if (!busy)           stat = ST_NONE;
    else if (cap_write_q) stat = ST_WRITE;
    else                 stat = ST_READ;
    rdata     = rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_write_q <= 1'b0;
      cap_io_q    <= 1'b0;
      cap_addr_q  <= '0;
      cap_wdata_q <= '0;
    end else if (accept) begin
      cap_write_q <= req_write;
      cap_io_q    <= req_io;
      cap_addr_q  <= req_addr;
      cap_wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rdata_q <= '0;
    else if (rd_sample) rdata_q <= ad_in;
  end

  // R10: strobes mutually exclusive
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  // R10: no strobe while the address strobe is high
  p_no_strobe_in_t1_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n));
  // R4: lane released while the device may drive it
  p_lane_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);
  // R3: upper address steady while a strobe stays low
  p_hi_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((!rd_n || !wr_n) && $past(!rd_n || !wr_n)) |-> $stable(addr_hi));
  // R6: space select steady across the strobe phase
  p_space_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((!rd_n || !wr_n) && $past(ale || !rd_n || !wr_n)) |-> $stable(io_m));
  // R2: address strobe lasts one clock
  p_ale_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  logic unused_hw;
  assign unused_hw = (HW > 0);
endmodule

// File: rtl/mbus_addr_latch.sv
module mbus_addr_latch #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ale,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_d;

  always_comb q_d = ale ? ad_in : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

  // R8: captured byte held until the next address strobe
  p_hold_between_strobes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ale) |-> $stable(q));
endmodule

// File: rtl/mbus_cycle_ctrl.sv
module mbus_cycle_ctrl
  import mbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_io,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_ready,
  output logic             done,
  output logic [DW-1:0]    rdata,
  output logic [AW-DW-1:0] addr_hi,
  inout  wire  [DW-1:0]    ad,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n,
  output logic             io_m,
  output logic [1:0]       stat,
  output logic [DW-1:0]    lat_addr_lo
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  tstate_e       state;
  logic          accept;
  logic [DW-1:0] ad_out;
  logic          ad_oe;
  logic [DW-1:0] ad_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign ad    = ad_oe ? ad_out : {DW{1'bz}};
  assign ad_in = ad;
  assign req_ready = (state == TS_IDLE);

  mbus_seq i_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .state_q   (state),
    .accept    (accept),
    .done_q    (done)
  );

  mbus_lane #(.AW(AW), .DW(DW)) i_lane (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .state     (state),
    .accept    (accept),
    .req_write (req_write),
    .req_io    (req_io),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ad_in     (ad_in),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .addr_hi   (addr_hi),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .io_m      (io_m),
    .stat      (stat),
    .rdata     (rdata)
  );

  mbus_addr_latch #(.DW(DW)) i_latch (
    .clk   (clk),
    .rst_n (rst_int_n),
    .ale   (ale),
    .ad_in (ad_in),
    .q     (lat_addr_lo)
  );
endmodule

// File: tb/test_mbus_cycle_ctrl.sv
module test_mbus_cycle_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_io;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready, done;
  logic [7:0]  rdata, addr_hi, lat_addr_lo;
  wire  [7:0]  ad;
  logic        ale, rd_n, wr_n, io_m;
  logic [1:0]  stat;
  logic [7:0]  mdl;
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;

  always #4 clk = ~clk;

  assign ad = (!rd_n) ? mdl : 8'bz;

  mbus_cycle_ctrl i_mbus_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .done(done), .rdata(rdata), .addr_hi(addr_hi),
    .ad(ad), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .stat(stat),
    .lat_addr_lo(lat_addr_lo)
  );

  function automatic logic [7:0] dev_byte(input logic [15:0] a);
    return a[15:8] ^ {a[3:0], a[7:4]} ^ 8'hA5;
  endfunction

  function automatic logic [1:0] exp_stat(input logic w);
    return w ? 2'b01 : 2'b10;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_cycle(input logic w, input logic io, input logic [15:0] a,
                           input logic [7:0] wd, input logic poke_busy);
    mdl = dev_byte(a);
    chk(req_ready == 1'b1, "R11 ready before request", {15'd0, req_ready}, 16'd1);
    req_valid = 1'b1; req_write = w; req_io = io; req_addr = a; req_wdata = wd;
    @(negedge clk); // T1
    req_valid = 1'b0;
    chk(ale == 1'b1, "R2 ale in T1", {15'd0, ale}, 16'd1);
    chk(ad == a[7:0], "R2 low address on lane", {8'd0, ad}, {8'd0, a[7:0]});
    chk(rd_n && wr_n, "R10 strobes high in T1", {14'd0, rd_n, wr_n}, 16'd3);
    chk(addr_hi == a[15:8], "R3 addr_hi in T1", {8'd0, addr_hi}, {8'd0, a[15:8]});
    chk(io_m == io, "R6 space in T1", {15'd0, io_m}, {15'd0, io});
    chk(stat == exp_stat(w), "R7 status in T1", {14'd0, stat}, {14'd0, exp_stat(w)});
    chk(req_ready == 1'b0, "R11 busy in T1", {15'd0, req_ready}, 16'd0);
    @(negedge clk); // T2
    chk(ale == 1'b0, "R2 ale single clock", {15'd0, ale}, 16'd0);
    if (w) begin
      chk(!wr_n && rd_n, "R5 write strobe T2", {14'd0, rd_n, wr_n}, 16'd2);
      chk(ad == wd, "R5 write data T2", {8'd0, ad}, {8'd0, wd});
    end else begin
      chk(!rd_n && wr_n, "R4 read strobe T2", {14'd0, rd_n, wr_n}, 16'd1);
      chk(ad == mdl, "R4 lane released T2", {8'd0, ad}, {8'd0, mdl});
    end
    chk(lat_addr_lo == a[7:0], "R8 latched low address T2", {8'd0, lat_addr_lo}, {8'd0, a[7:0]});
    chk(io_m == io, "R6 space in T2", {15'd0, io_m}, {15'd0, io});
    if (poke_busy) begin
      req_valid = 1'b1; req_addr = ~a; req_write = ~w; req_io = ~io; req_wdata = ~wd;
    end
    @(negedge clk); // T3
    req_valid = 1'b0;
    chk(addr_hi == a[15:8], "R3 addr_hi in T3", {8'd0, addr_hi}, {8'd0, a[15:8]});
    chk(stat == exp_stat(w), "R7 status in T3", {14'd0, stat}, {14'd0, exp_stat(w)});
    chk(io_m == io, "R6 space in T3", {15'd0, io_m}, {15'd0, io});
    if (w) chk(!wr_n && ad == wd, "R5 write T3", {7'd0, wr_n, ad}, {8'd0, wd});
    else   chk(!rd_n && wr_n, "R4 read strobe T3", {14'd0, rd_n, wr_n}, 16'd1);
    chk(lat_addr_lo == a[7:0], "R8 latched low address T3", {8'd0, lat_addr_lo}, {8'd0, a[7:0]});
    @(negedge clk); // idle, done
    chk(done == 1'b1, "R9 done pulse", {15'd0, done}, 16'd1);
    if (!w) chk(rdata == dev_byte(a), "R9 read data", {8'd0, rdata}, {8'd0, dev_byte(a)});
    chk(rd_n && wr_n && !ale, "R10 strobes released", {13'd0, ale, rd_n, wr_n}, 16'd3);
    chk(stat == 2'b00, "R7 status idle", {14'd0, stat}, 16'd0);
    chk(lat_addr_lo == a[7:0], "R8 hold after cycle", {8'd0, lat_addr_lo}, {8'd0, a[7:0]});
    @(negedge clk);
    chk(done == 1'b0, "R9 done one clock", {15'd0, done}, 16'd0);
    if (poke_busy)
      chk(ale == 1'b0, "R11 busy request dropped", {15'd0, ale}, 16'd0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_io = 1'b0;
    req_addr = '0; req_wdata = '0; mdl = '0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready in reset", {15'd0, req_ready}, 16'd1);
    chk(rd_n && wr_n && !ale, "R1 strobes in reset", {13'd0, ale, rd_n, wr_n}, 16'd3);
    chk(stat == 2'b00 && !done, "R1 status in reset", {13'd0, done, stat}, 16'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rd_n && wr_n && !ale && !done, "R1 idle after release",
        {12'd0, done, ale, rd_n, wr_n}, 16'd3);
    // directed corners
    run_cycle(1'b0, 1'b0, 16'h0000, 8'h00, 1'b0);
    run_cycle(1'b1, 1'b0, 16'hFFFF, 8'hFF, 1'b0);
    run_cycle(1'b1, 1'b1, 16'h00FF, 8'h00, 1'b0);
    run_cycle(1'b0, 1'b1, 16'hFF00, 8'h5A, 1'b0);
    run_cycle(1'b0, 1'b0, 16'h1234, 8'h00, 1'b1);
    run_cycle(1'b1, 1'b1, 16'hABCD, 8'h3C, 1'b1);
    // random
    void'($urandom(32'd1357));
    for (int i = 0; i < 60; i++) begin
      logic [31:0] r;
      r = $urandom;
      run_cycle(r[0], r[1], r[31:16], r[15:8], r[2] & r[3]);
      if (r[4]) @(negedge clk);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule